// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages the packet buffer of a network controller. The buffer RAM is cut into fixed pages of 256 bytes. A host issues commands on a small command port. The block hands out pages together with a packet number, and takes them back when a packet is freed. Page ownership is kept in a free-page bitmap plus one page mask per packet number. A second bitmap tracks which packet numbers are free.

The host sizes each request from the frame length plus 6 bytes of overhead, rounded up to whole pages. It writes that page count minus one as the command argument. An allocation that cannot be met sets a failure flag and changes nothing. The request then stays pending and is retried by itself after every free or release command. A successful allocation sets a sticky completion event, which the host can poll or enable onto an interrupt line.

Two queues sit next to the allocator. A receive queue is filled by the MAC with packet numbers and drained by the release command. A transmit queue is filled by the enqueue command and drained by the MAC. Every accepted command holds a busy flag for a fixed number of cycles. Commands offered while busy are dropped.

Top module: `pbuf_page_alloc`

## Requirements
- R1: After reset all 32 pages and all 32 packet numbers are free. `busy`, `alloc_fail` and `alloc_int` are low, and both queues are empty.
- R2: An accepted command with `cmd_op`=1 (allocate) and `cmd_arg`=n claims n+1 pages. It returns in `alloc_pkt` the lowest free packet number and clears `alloc_fail`.
- R3: When fewer pages or no packet numbers are free, an allocate sets `alloc_fail`. It leaves `free_pages` and all packet state unchanged, and the request becomes pending.
- R4: `busy` is high for exactly 4 cycles after the clock edge that accepts a command.
- R5: A command offered while `busy` is high is ignored and has no effect on any state.
- R6: A pending allocation is retried automatically after every free or release command. It completes as soon as enough pages and a packet number are free.
- R7: Each successful allocation sets `alloc_int`, and `alloc_ack` clears it. `alloc_irq` equals `alloc_int` AND `irq_en`.
- R8: `cmd_op`=2 (reset) returns every page and packet number to the free pool. It also cancels a pending request and empties both queues.
- R9: `cmd_op`=3 (free) returns the pages of the packet named by `sel_pkt`. Freeing a packet that holds no pages changes no page count.
- R10: `cmd_op`=4 (release) frees the packet at the head of the receive queue and pops it. With the receive queue empty, the command has no effect.
- R11: `cmd_op`=5 (enqueue) pushes `sel_pkt` onto the transmit queue, which shows its head on `tx_head`. `tx_pop` removes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 allocate, 2 reset, 3 free, 4 release, 5 enqueue) |
| cmd_arg | input | 5 | Pages requested minus one |
| sel_pkt | input | 5 | Selected packet number for free and enqueue |
| rx_push | input | 1 | MAC stores a received packet number |
| rx_pkt | input | 5 | Received packet number |
| tx_pop | input | 1 | MAC takes the transmit queue head |
| irq_en | input | 1 | Enables the completion interrupt |
| alloc_ack | input | 1 | Clears the completion event |
| busy | output | 1 | Command in progress |
| alloc_pkt | output | 5 | Packet number of the last successful allocation |
| alloc_fail | output | 1 | Last allocation attempt failed |
| alloc_int | output | 1 | Sticky allocation-complete event |
| alloc_irq | output | 1 | Enabled completion interrupt |
| free_pages | output | 6 | Number of free pages |
| rx_empty | output | 1 | Receive queue empty |
| tx_head | output | 5 | Transmit queue head |
| tx_empty | output | 1 | Transmit queue empty |

## Verification
The embedded assertions check the following on every cycle:
- the busy countdown and what starts it;
- that a failed allocation leaves the page bitmap untouched;
- that the completion event rises only on a success;
- the full free pool after a reset command;
- queue occupancy after a push.

Other behaviours can only be shown by the bench's scenarios, which are a seeded random command stream checked against a reference model:
- lowest-number packet selection;
- exact page accounting across mixed free and release traffic;
- automatic completion of a pending request;
- the ordering of the transmit queue.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_FREE    = 3'd3,
    OP_RELEASE = 3'd4,
    OP_ENQ     = 3'd5
  } pba_op_e;
endpackage

// File: rtl/pba_page_pick.sv
// Selects the lowest-indexed free pages up to the requested count.
module pba_page_pick #(
  parameter int N  = 32,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  free_map,
  input  logic [CW-1:0] need,
  output logic [N-1:0]  grant,
  output logic          ok
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] taken;

  always_comb begin
    grant = '0;
    taken = '0;
    for (int i = 0; i < N; i++) begin
      if (free_map[i] && (taken < need)) begin
        grant[i] = 1'b1;
        taken    = taken + ONE;
      end
    end
    ok = (taken == need);
  end
endmodule

// File: rtl/pba_lowest_free.sv
// Priority pick of the lowest set bit of a map.
module pba_lowest_free #(
  parameter int N = 32,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] map,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (map[i]) idx = W'(i);
    end
    any = |map;
  end
endmodule

// File: rtl/pba_fifo.sv
module pba_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q, wr_n, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (clear) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = wr_q + PW'(1);
      if (do_pop)  rd_n = rd_q + PW'(1);
      if (do_push && !do_pop) cnt_n = cnt_q + CW'(1);
      if (do_pop && !do_push) cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_q] <= push_data;
  end

  // R10 R11
  q_push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop && !clear) |=> !empty);
endmodule

// File: rtl/pbuf_page_alloc.sv
module pbuf_page_alloc #(
  parameter int PAGE_BYTES = 256,
  parameter int RAM_BYTES  = 8192,
  parameter int NUM_PKTS   = 32,
  parameter int BUSY_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [4:0] cmd_arg,
  input  logic [4:0] sel_pkt,
  input  logic       rx_push,
  input  logic [4:0] rx_pkt,
  input  logic       tx_pop,
  input  logic       irq_en,
  input  logic       alloc_ack,
  output logic       busy,
  output logic [4:0] alloc_pkt,
  output logic       alloc_fail,
  output logic       alloc_int,
  output logic       alloc_irq,
  output logic [5:0] free_pages,
  output logic       rx_empty,
  output logic [4:0] tx_head,
  output logic       tx_empty
);
  import pba_pkg::*;

  localparam int NUM_PAGES = RAM_BYTES / PAGE_BYTES;
  localparam int PKT_W     = $clog2(NUM_PKTS);
  localparam int CNT_W     = $clog2(NUM_PAGES + 1);
  localparam int BSY_W     = $clog2(BUSY_CYC + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_q_n <= rst_s1;
    end
  end

  logic [NUM_PAGES-1:0] page_free, page_free_n;
  logic [NUM_PKTS-1:0]  pkt_free, pkt_free_n;
  logic [NUM_PAGES-1:0] pkt_pages [NUM_PKTS];
  logic [NUM_PAGES-1:0] pkt_pages_n [NUM_PKTS];
  logic                 pend_q, pend_n, retry_q, retry_n;
  logic [CNT_W-1:0]     pend_need_q, pend_need_n;
  logic [PKT_W-1:0]     res_pkt_q, res_pkt_n;
  logic                 fail_q, fail_n, int_q, int_n;
  logic [BSY_W-1:0]     busy_cnt, busy_cnt_n;

  pba_op_e          op;
  logic             acc, is_alloc, is_reset, free_en, try_alloc, ok;
  logic [CNT_W-1:0] try_need;
  logic [NUM_PAGES-1:0] grant;
  logic             pg_ok, pkt_any;
  logic [PKT_W-1:0] pkt_idx, free_idx, rx_head;
  logic             rx_full, tx_full, rx_q_empty;

  assign op        = pba_op_e'(cmd_op);
  assign acc       = cmd_valid && (busy_cnt == '0);
  assign is_alloc  = acc && (op == OP_ALLOC);
  assign is_reset  = acc && (op == OP_RESET);
  assign free_en   = acc && ((op == OP_FREE) || ((op == OP_RELEASE) && !rx_q_empty));
  assign free_idx  = (op == OP_FREE) ? sel_pkt : rx_head;
  assign try_alloc = is_alloc || (pend_q && retry_q);
  assign try_need  = is_alloc ? (CNT_W'(cmd_arg) + CNT_W'(1)) : pend_need_q;
  assign ok        = pg_ok && pkt_any;

  pba_page_pick #(.N(NUM_PAGES), .CW(CNT_W)) u_pick (
    .free_map(page_free), .need(try_need), .grant(grant), .ok(pg_ok));

  pba_lowest_free #(.N(NUM_PKTS), .W(PKT_W)) u_pnum (
    .map(pkt_free), .idx(pkt_idx), .any(pkt_any));

  pba_fifo #(.DEPTH(NUM_PKTS), .W(PKT_W)) u_rxq (
    .clk(clk), .rst_n(rst_q_n), .clear(is_reset),
    .push(rx_push && !rx_full), .push_data(rx_pkt),
    .pop(acc && (op == OP_RELEASE)), .head(rx_head),
    .empty(rx_q_empty), .full(rx_full));

  pba_fifo #(.DEPTH(NUM_PKTS), .W(PKT_W)) u_txq (
    .clk(clk), .rst_n(rst_q_n), .clear(is_reset),
    .push(acc && (op == OP_ENQ) && !tx_full), .push_data(sel_pkt),
    .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full));

  always_comb begin
    page_free_n = page_free;
    pkt_free_n  = pkt_free;
    pkt_pages_n = pkt_pages;
    pend_n      = pend_q;
    pend_need_n = pend_need_q;
    res_pkt_n   = res_pkt_q;
    fail_n      = fail_q;
    retry_n     = 1'b0;
    int_n       = alloc_ack ? 1'b0 : int_q;
    busy_cnt_n  = (busy_cnt != '0) ? busy_cnt - BSY_W'(1) : '0;
    if (acc) busy_cnt_n = BSY_W'(BUSY_CYC);

    if (is_reset) begin
      page_free_n = '1;
      pkt_free_n  = '1;
      for (int k = 0; k < NUM_PKTS; k++) pkt_pages_n[k] = '0;
      pend_n    = 1'b0;
      fail_n    = 1'b0;
      res_pkt_n = '0;
    end else if (free_en) begin
      page_free_n           = page_free | pkt_pages[free_idx];
      pkt_free_n[free_idx]  = 1'b1;
      pkt_pages_n[free_idx] = '0;
      retry_n               = 1'b1;
    end else if (try_alloc) begin
      if (ok) begin
        page_free_n          = page_free & ~grant;
        pkt_free_n[pkt_idx]  = 1'b0;
        pkt_pages_n[pkt_idx] = grant;
        res_pkt_n            = pkt_idx;
        fail_n               = 1'b0;
        pend_n               = 1'b0;
        int_n                = 1'b1;
      end else begin
        fail_n      = 1'b1;
        pend_n      = 1'b1;
        pend_need_n = try_need;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      page_free   <= '1;
      pkt_free    <= '1;
      for (int k = 0; k < NUM_PKTS; k++) pkt_pages[k] <= '0;
      pend_q      <= 1'b0;
      pend_need_q <= '0;
      res_pkt_q   <= '0;
      fail_q      <= 1'b0;
      int_q       <= 1'b0;
      retry_q     <= 1'b0;
      busy_cnt    <= '0;
    end else begin
      page_free   <= page_free_n;
      pkt_free    <= pkt_free_n;
      pkt_pages   <= pkt_pages_n;
      pend_q      <= pend_n;
      pend_need_q <= pend_need_n;
      res_pkt_q   <= res_pkt_n;
      fail_q      <= fail_n;
      int_q       <= int_n;
      retry_q     <= retry_n;
      busy_cnt    <= busy_cnt_n;
    end
  end

  assign busy       = (busy_cnt != '0);
  assign alloc_pkt  = res_pkt_q;
  assign alloc_fail = fail_q;
  assign alloc_int  = int_q;
  assign alloc_irq  = int_q && irq_en;
  assign free_pages = CNT_W'($countones(page_free));
  assign rx_empty   = rx_q_empty;

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(busy) |-> $past(cmd_valid));
  // R5
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - BSY_W'(1)));
  // R3
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(is_alloc) && alloc_fail) |-> (page_free == $past(page_free)));
  // R7
  int_success_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(alloc_int) |-> !alloc_fail);
  // R8
  reset_pool_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(is_reset) |-> (free_pages == CNT_W'(NUM_PAGES)));
endmodule

// File: tb/pbuf_page_alloc_tb_top.sv
`timescale 1ns/1ps
module pbuf_page_alloc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, rx_push, tx_pop, irq_en, alloc_ack;
  logic [2:0] cmd_op;
  logic [4:0] cmd_arg, sel_pkt, rx_pkt;
  logic       busy, alloc_fail, alloc_int, alloc_irq, rx_empty, tx_empty;
  logic [4:0] alloc_pkt, tx_head;
  logic [5:0] free_pages;

  always #2 clk = ~clk;

  pbuf_page_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .sel_pkt(sel_pkt), .rx_push(rx_push), .rx_pkt(rx_pkt),
    .tx_pop(tx_pop), .irq_en(irq_en), .alloc_ack(alloc_ack), .busy(busy),
    .alloc_pkt(alloc_pkt), .alloc_fail(alloc_fail), .alloc_int(alloc_int),
    .alloc_irq(alloc_irq), .free_pages(free_pages), .rx_empty(rx_empty),
    .tx_head(tx_head), .tx_empty(tx_empty));

  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  int m_free;
  bit m_used [32];
  int m_pages [32];
  bit m_pend, m_fail, m_int;
  int m_need, m_last;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pages_for_len(int len);
    return (len + 6 + 255) / 256;
  endfunction

  function automatic int lowest_free_pkt();
    for (int k = 0; k < 32; k++) if (!m_used[k]) return k;
    return -1;
  endfunction

  task automatic m_reset();
    m_free = 32; m_pend = 0; m_fail = 0; m_last = 0;
    for (int k = 0; k < 32; k++) begin m_used[k] = 0; m_pages[k] = 0; end
  endtask

  task automatic m_try(int need);
    int p;
    p = lowest_free_pkt();
    if (need <= m_free && p >= 0) begin
      m_free -= need; m_used[p] = 1; m_pages[p] = need;
      m_last = p; m_fail = 0; m_pend = 0; m_int = 1;
    end else begin
      m_fail = 1; m_pend = 1; m_need = need;
    end
  endtask

  task automatic m_release(int k);
    if (m_used[k]) begin
      m_free += m_pages[k]; m_used[k] = 0; m_pages[k] = 0;
    end
    if (m_pend) m_try(m_need);
  endtask

  task automatic issue(logic [2:0] op, int arg, int sel);
    while (busy) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_arg = 5'(arg); sel_pkt = 5'(sel);
    @(negedge clk);
    cmd_valid = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic push_rx(int k);
    rx_push = 1; rx_pkt = 5'(k);
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic compare(string req);
    check({req, " free_pages"}, int'(free_pages), m_free);
    check({req, " alloc_fail"}, int'(alloc_fail), int'(m_fail));
    if (!m_fail) check({req, " alloc_pkt"}, int'(alloc_pkt), m_last);
  endtask

  task automatic do_alloc(int need, string req);
    issue(3'd1, need - 1, 0);
    m_try(need);
    compare(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int bcnt, r, k, got_head;
    void'($urandom(32'd1234));
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_arg = 0; sel_pkt = 0;
    rx_push = 0; rx_pkt = 0; tx_pop = 0; irq_en = 0; alloc_ack = 0;
    m_reset(); m_int = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 free_pages", int'(free_pages), 32);
    check("R1 busy", int'(busy), 0);
    check("R1 alloc_fail", int'(alloc_fail), 0);
    check("R1 alloc_int", int'(alloc_int), 0);
    check("R1 rx_empty", int'(rx_empty), 1);
    check("R1 tx_empty", int'(tx_empty), 1);

    // R4 busy window length
    cmd_valid = 1; cmd_op = 3'd1; cmd_arg = 5'(pages_for_len(60) - 1);
    @(negedge clk);
    cmd_valid = 0;
    bcnt = 0;
    while (busy) begin bcnt++; @(negedge clk); end
    m_try(pages_for_len(60));
    check("R4 busy cycles", bcnt, 4);
    compare("R2 first alloc");

    // R5 command while busy is ignored
    cmd_valid = 1; cmd_op = 3'd1; cmd_arg = 5'd1;
    @(negedge clk);
    cmd_op = 3'd1; cmd_arg = 5'd4;
    @(negedge clk);
    cmd_valid = 0;
    while (busy) @(negedge clk);
    m_try(2);
    check("R5 ignored while busy", int'(free_pages), m_free);
    compare("R2 second alloc");

    // R7 completion event and interrupt
    check("R7 alloc_int set", int'(alloc_int), 1);
    check("R7 irq masked", int'(alloc_irq), 0);
    irq_en = 1; #0;
    @(negedge clk);
    check("R7 irq enabled", int'(alloc_irq), 1);
    alloc_ack = 1;
    @(negedge clk);
    alloc_ack = 0; m_int = 0;
    check("R7 ack clears", int'(alloc_int), 0);
    irq_en = 0;

    // R3 failure keeps state, R6 retry on free
    do_alloc(pages_for_len(1514), "R2 frame alloc");
    do_alloc(32, "R3 oversize");
    check("R3 fail flag", int'(alloc_fail), 1);
    do_alloc(29, "R3 still short");
    issue(3'd3, 0, 1);
    m_release(1);
    compare("R9 free pkt1 retry");
    issue(3'd3, 0, 0);
    m_release(0);
    compare("R6 retry after free");
    issue(3'd3, 0, 2);
    m_release(2);
    compare("R6 retry completes");
    check("R6 success", int'(alloc_fail), 0);

    // R8 reset command
    push_rx(3);
    issue(3'd5, 0, 7);
    issue(3'd2, 0, 0);
    m_reset();
    compare("R8 reset cmd");
    check("R8 rx emptied", int'(rx_empty), 1);
    check("R8 tx emptied", int'(tx_empty), 1);

    // R9 free of an unused packet
    do_alloc(3, "R2 small");
    issue(3'd3, 0, 20);
    m_release(20);
    compare("R9 unused free");

    // R10 release on empty queue, then from queue
    issue(3'd4, 0, 0);
    compare("R10 empty release");
    push_rx(0);
    issue(3'd4, 0, 0);
    m_release(0);
    compare("R10 release head");
    check("R10 popped", int'(rx_empty), 1);

    // R11 transmit queue order
    issue(3'd5, 0, 9);
    issue(3'd5, 0, 14);
    check("R11 head first", int'(tx_head), 9);
    tx_pop = 1; @(negedge clk); tx_pop = 0;
    check("R11 head second", int'(tx_head), 14);
    tx_pop = 1; @(negedge clk); tx_pop = 0;
    check("R11 drained", int'(tx_empty), 1);

    // random mix against the model
    for (int it = 0; it < 400; it++) begin
      r = $urandom_range(0, 19);
      if (r < 8) begin
        do_alloc($urandom_range(1, 6), "R2 rand alloc");
      end else if (r < 13) begin
        k = $urandom_range(0, 31);
        issue(3'd3, 0, k);
        m_release(k);
        compare("R9 rand free");
      end else if (r < 17) begin
        k = lowest_free_pkt();
        k = (k == 0) ? 1 : 0;
        k = m_used[k] ? k : $urandom_range(0, 31);
        push_rx(k);
        issue(3'd4, 0, 0);
        m_release(k);
        compare("R10 rand release");
      end else if (r < 19) begin
        k = $urandom_range(0, 31);
        issue(3'd5, 0, k);
        got_head = int'(tx_head);
        check("R11 rand enqueue", got_head, k);
        tx_pop = 1; @(negedge clk); tx_pop = 0;
      end else begin
        issue(3'd2, 0, 0);
        m_reset();
        compare("R8 rand reset");
      end
    end
    finish_run();
  end
endmodule